// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of a two-bank SDRAM and owns the command pins from reset until the memory is usable. It waits out the power-up interval with the bus idle. It then closes both banks and runs the initial burst of auto-refresh cycles. It also programs the mode register from three configuration fields: CAS latency, burst ordering and burst length. The mode-register write can come either before or after the refresh burst, chosen by one input. All delays are counted in clock cycles, and the cycle counts are derived at elaboration from nanosecond parameters and the clock period.

After initialization, a timer raises a refresh request at a fixed cycle interval. The block withdraws its bus grant from the host arbiter as soon as a request is pending. Once the host reports it is idle, the block closes both banks and issues one auto-refresh. It returns the bus when the refresh recovery time has elapsed. A configuration that uses a reserved encoding is never written to the device. Instead an error flag is raised and initialization waits at that step until the fields become legal.

Top module: `sdr_init_refresh_seq`

## Requirements
- R1: During reset and for exactly POWERUP_CYC = ceil(POWERUP_NS / CLK_PERIOD_NS) cycles after reset is released, the command pins show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1). init_done, bus_grant and cfg_error stay low over that time.
- R2: The first command after the power-up wait is precharge (cs_n=0, ras_n=0, cas_n=1, we_n=0) with sdr_addr[10]=1 to close both banks. It is issued in cycle POWERUP_CYC+1 after reset release.
- R3: Initialization issues exactly INIT_REFS auto-refresh commands (cs_n=0, ras_n=0, cas_n=0, we_n=1), and all of them come before init_done rises.
- R4: cfg_mrs_first is sampled when the initial precharge is issued. A value of 1 places the mode-register write directly after the precharge and before the refreshes. A value of 0 places it after the last refresh.
- R5: The mode-register write drives all four command pins low, with sdr_addr[2:0]=burst length code, sdr_addr[3]=burst type, sdr_addr[6:4]=CAS latency code, and sdr_addr[10:7] and sdr_bank at 0.
- R6: A setting is legal when the CAS latency code is 1, 2 or 3 and the burst length code is 0 to 3, or 7 with burst type 0. At the mode-write step, an illegal setting keeps the pins at NOP and holds cfg_error high. No refresh or later step runs until the setting becomes legal. The write is then issued in the next cycle and cfg_error clears.
- R7: The command after a mode-register write comes exactly TMRD_CYC cycles later (2 by default).
- R8: The command after a precharge comes exactly ceil(TRP_NS/CLK_PERIOD_NS) cycles later. The command after an auto-refresh comes exactly ceil(TRC_NS/CLK_PERIOD_NS) cycles later.
- R9: Once init_done is high, a refresh request rises every REFI_CYC = floor(REFI_NS/CLK_PERIOD_NS) cycles. bus_grant falls in the cycle the request rises, which is REFI_CYC cycles after init_done first rises.
- R10: While a request is pending and host_idle is low, no command is issued. When host_idle is seen high at a clock edge, a both-bank precharge (sdr_addr[10]=1) follows in the next cycle, and an auto-refresh follows the tRP cycle count after that.
- R11: init_done rises exactly the final step's spacing (R7 or R8) after the last initialization command. bus_grant is high only when init_done is high, no request is pending and the spacing after the last refresh has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cas_lat | input | 3 | CAS latency code for the mode register |
| cfg_burst_type | input | 1 | Burst ordering: 0 sequential, 1 interleaved |
| cfg_burst_len | input | 3 | Burst length code for the mode register |
| cfg_mrs_first | input | 1 | 1: mode write before the refresh burst; 0: after it |
| host_idle | input | 1 | Host has no command outstanding and can give up the bus |
| sdr_cs_n | output | 1 | Chip select, active low |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_bank | output | 1 | Bank select bit |
| sdr_addr | output | ADDR_W | Address bits; bit 10 selects both banks on precharge |
| init_done | output | 1 | Initialization finished and its spacing elapsed |
| bus_grant | output | 1 | Host may drive the command bus |
| cfg_error | output | 1 | Reserved mode setting is blocking the mode write |

## Verification
A wrong step register or order bit shows up at the ports right away. The pin encoding after the precharge would be wrong, or the mode write would appear in the wrong slot of the command log. A miscounted spacing counter moves every later command and the init_done edge by the same number of cycles, so the first distance compared is already off. A faulty refresh counter or request latch would move the bus_grant fall away from its exact REFI_CYC position, or would let commands through while host_idle is low. The bench catches this within one refresh interval.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdr_cmd_t;

    localparam sdr_cmd_t CMD_NOP = 4'b0111;
    localparam sdr_cmd_t CMD_PRE = 4'b0010;
    localparam sdr_cmd_t CMD_REF = 4'b0001;
    localparam sdr_cmd_t CMD_MRS = 4'b0000;

    typedef struct packed {
        logic [2:0] cas_lat;
        logic       interleave;
        logic [2:0] burst_len;
    } mode_cfg_t;

    typedef enum logic [2:0] {
        STEP_PRE,
        STEP_MRS,
        STEP_REF,
        STEP_DONE,
        STEP_READY,
        STEP_RREF
    } step_e;

    function automatic int cyc_ceil(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int cyc_floor(input int ns, input int period);
        int c;
        c = ns / period;
        return (c < 2) ? 2 : c;
    endfunction

    function automatic logic mode_is_legal(input mode_cfg_t m);
        logic cl_ok;
        logic bl_ok;
        cl_ok = (m.cas_lat != 3'd0) && (m.cas_lat <= 3'd3);
        bl_ok = (m.burst_len <= 3'd3) || ((m.burst_len == 3'd7) && !m.interleave);
        return cl_ok && bl_ok;
    endfunction

endpackage

// File: rtl/sdr_mode_encoder.sv
module sdr_mode_encoder
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  mode_cfg_t         cfg,
    output logic              legal,
    output logic [ADDR_W-1:0] word
);
    localparam int FIELD_W = $bits(mode_cfg_t);

    always_comb begin
        legal = mode_is_legal(cfg);
        word  = '0;
        word[FIELD_W-1:0] = cfg;
    end
endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int INTERVAL = 780
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic ack,
    output logic pending
);
    localparam int TW = $clog2(INTERVAL + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q   <= '0;
            pending <= 1'b0;
        end else if (cnt_q == TW'(INTERVAL - 1)) begin
            cnt_q   <= '0;
            pending <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (ack) pending <= 1'b0;
        end
    end
endmodule

// File: rtl/sdr_cmd_fsm.sv
module sdr_cmd_fsm
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int POWERUP_CYC = 10000,
    parameter int TRP_CYC     = 1,
    parameter int TRC_CYC     = 4,
    parameter int TMRD_CYC    = 2,
    parameter int INIT_REFS   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mrs_first,
    input  logic              mode_legal,
    input  logic [ADDR_W-1:0] mode_word,
    input  logic              refresh_due,
    input  logic              host_idle,
    output sdr_cmd_t          cmd,
    output logic [ADDR_W-1:0] addr,
    output logic              bank,
    output logic              init_done,
    output logic              cfg_error,
    output logic              bus_grant,
    output logic              refresh_ack
);
    localparam int GW = $clog2(POWERUP_CYC + TRP_CYC + TRC_CYC + TMRD_CYC + 1);
    localparam int RW = $clog2(INIT_REFS + 1);
    localparam int AP = 10;

    step_e          step_q;
    logic [GW-1:0]  gap_q;
    logic [RW-1:0]  refs_left_q;
    logic           order_mrs_first_q;

    assign refresh_ack = (step_q == STEP_RREF) && (gap_q == '0);
    assign bus_grant   = (step_q == STEP_READY) && (gap_q == '0) && !refresh_due;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q            <= STEP_PRE;
            gap_q             <= GW'(POWERUP_CYC);
            refs_left_q       <= RW'(INIT_REFS);
            order_mrs_first_q <= 1'b0;
            cmd               <= CMD_NOP;
            addr              <= '0;
            bank              <= 1'b0;
            init_done         <= 1'b0;
            cfg_error         <= 1'b0;
        end else begin
            cmd  <= CMD_NOP;
            addr <= '0;
            bank <= 1'b0;
            if (gap_q != '0) begin
                gap_q <= gap_q - 1'b1;
            end else begin
                unique case (step_q)
                    STEP_PRE: begin
                        cmd               <= CMD_PRE;
                        addr[AP]          <= 1'b1;
                        gap_q             <= GW'(TRP_CYC - 1);
                        order_mrs_first_q <= mrs_first;
                        step_q            <= mrs_first ? STEP_MRS : STEP_REF;
                    end
                    STEP_MRS: begin
                        if (!mode_legal) begin
                            cfg_error <= 1'b1;
                        end else begin
                            cfg_error <= 1'b0;
                            cmd       <= CMD_MRS;
                            addr      <= mode_word;
                            gap_q     <= GW'(TMRD_CYC - 1);
                            step_q    <= order_mrs_first_q ? STEP_REF : STEP_DONE;
                        end
                    end
                    STEP_REF: begin
                        cmd         <= CMD_REF;
                        gap_q       <= GW'(TRC_CYC - 1);
                        refs_left_q <= refs_left_q - 1'b1;
                        if (refs_left_q == RW'(1))
                            step_q <= order_mrs_first_q ? STEP_DONE : STEP_MRS;
                    end
                    STEP_DONE: begin
                        init_done <= 1'b1;
                        step_q    <= STEP_READY;
                    end
                    STEP_READY: begin
                        if (refresh_due && host_idle) begin
                            cmd      <= CMD_PRE;
                            addr[AP] <= 1'b1;
                            gap_q    <= GW'(TRP_CYC - 1);
                            step_q   <= STEP_RREF;
                        end
                    end
                    STEP_RREF: begin
                        cmd    <= CMD_REF;
                        gap_q  <= GW'(TRC_CYC - 1);
                        step_q <= STEP_READY;
                    end
                    default: step_q <= STEP_PRE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sdr_init_refresh_seq.sv
module sdr_init_refresh_seq
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W        = 11,
    parameter int CLK_PERIOD_NS = 20,
    parameter int POWERUP_NS    = 200000,
    parameter int TRP_NS        = 20,
    parameter int TRC_NS        = 70,
    parameter int TMRD_CYC      = 2,
    parameter int REFI_NS       = 15600,
    parameter int INIT_REFS     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_cas_lat,
    input  logic              cfg_burst_type,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_mrs_first,
    input  logic              host_idle,
    output logic              sdr_cs_n,
    output logic              sdr_ras_n,
    output logic              sdr_cas_n,
    output logic              sdr_we_n,
    output logic              sdr_bank,
    output logic [ADDR_W-1:0] sdr_addr,
    output logic              init_done,
    output logic              bus_grant,
    output logic              cfg_error
);
    localparam int POWERUP_CYC = cyc_ceil(POWERUP_NS, CLK_PERIOD_NS);
    localparam int TRP_CYC     = cyc_ceil(TRP_NS, CLK_PERIOD_NS);
    localparam int TRC_CYC     = cyc_ceil(TRC_NS, CLK_PERIOD_NS);
    localparam int REFI_CYC    = cyc_floor(REFI_NS, CLK_PERIOD_NS);

    mode_cfg_t         mode_cfg;
    logic              mode_legal;
    logic [ADDR_W-1:0] mode_word;
    logic              refresh_due;
    logic              refresh_ack;
    sdr_cmd_t          cmd_q;

    assign mode_cfg = '{cas_lat: cfg_cas_lat, interleave: cfg_burst_type, burst_len: cfg_burst_len};

    sdr_mode_encoder #(.ADDR_W(ADDR_W)) u_mode (
        .cfg   (mode_cfg),
        .legal (mode_legal),
        .word  (mode_word)
    );

    sdr_refresh_timer #(.INTERVAL(REFI_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (init_done),
        .ack     (refresh_ack),
        .pending (refresh_due)
    );

    sdr_cmd_fsm #(
        .ADDR_W      (ADDR_W),
        .POWERUP_CYC (POWERUP_CYC),
        .TRP_CYC     (TRP_CYC),
        .TRC_CYC     (TRC_CYC),
        .TMRD_CYC    (TMRD_CYC),
        .INIT_REFS   (INIT_REFS)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .mrs_first   (cfg_mrs_first),
        .mode_legal  (mode_legal),
        .mode_word   (mode_word),
        .refresh_due (refresh_due),
        .host_idle   (host_idle),
        .cmd         (cmd_q),
        .addr        (sdr_addr),
        .bank        (sdr_bank),
        .init_done   (init_done),
        .cfg_error   (cfg_error),
        .bus_grant   (bus_grant),
        .refresh_ack (refresh_ack)
    );

    assign sdr_cs_n  = cmd_q.cs_n;
    assign sdr_ras_n = cmd_q.ras_n;
    assign sdr_cas_n = cmd_q.cas_n;
    assign sdr_we_n  = cmd_q.we_n;
endmodule

// File: rtl/sdr_seq_checker.sv
module sdr_seq_checker #(
    parameter int ADDR_W      = 11,
    parameter int POWERUP_CYC = 10000,
    parameter int TRP_CYC     = 1,
    parameter int TRC_CYC     = 4,
    parameter int TMRD_CYC    = 2,
    parameter int INIT_REFS   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        cmd,
    input logic [ADDR_W-1:0] addr,
    input logic              bank,
    input logic              init_done,
    input logic              bus_grant,
    input logic              cfg_error,
    input logic              host_idle
);
    localparam int PW = $clog2(POWERUP_CYC + 2) + 1;

    logic [PW-1:0] since_rst_q;
    logic [15:0]   since_cmd_q;
    logic [7:0]    refs_q;
    logic [3:0]    last_cmd_q;
    logic          is_cmd;

    assign is_cmd = (cmd != 4'b0111);

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst_q <= '0;
            since_cmd_q <= '0;
            refs_q      <= '0;
            last_cmd_q  <= 4'b0111;
        end else begin
            if (since_rst_q <= PW'(POWERUP_CYC)) since_rst_q <= since_rst_q + 1'b1;
            if (is_cmd) begin
                since_cmd_q <= 16'd1;
                last_cmd_q  <= cmd;
            end else if (since_cmd_q != 16'hFFFF) begin
                since_cmd_q <= since_cmd_q + 1'b1;
            end
            if (cmd == 4'b0001 && refs_q != 8'hFF) refs_q <= refs_q + 1'b1;
        end
    end

    a_r1_powerup_nop: assert property (@(posedge clk) disable iff (rst)
        (since_rst_q <= PW'(POWERUP_CYC)) |-> (cmd == 4'b0111));

    a_r3_refs_before_done: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> (refs_q >= 8'(INIT_REFS)));

    a_r5_mode_fields: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0000) |-> (addr[10:7] == 4'd0 && !bank &&
                              addr[6:4] != 3'd0 && addr[6:4] <= 3'd3));

    a_r6_no_write_on_error: assert property (@(posedge clk) disable iff (rst)
        cfg_error |-> (cmd != 4'b0000));

    a_r7_mode_spacing: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && since_cmd_q != 16'd0 && last_cmd_q == 4'b0000) |-> (since_cmd_q >= 16'(TMRD_CYC)));

    a_r8_pre_spacing: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && since_cmd_q != 16'd0 && last_cmd_q == 4'b0010) |-> (since_cmd_q >= 16'(TRP_CYC)));

    a_r8_ref_spacing: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && since_cmd_q != 16'd0 && last_cmd_q == 4'b0001) |-> (since_cmd_q >= 16'(TRC_CYC)));

    a_r10_host_idle_first: assert property (@(posedge clk) disable iff (rst)
        (init_done && $past(init_done) && cmd == 4'b0010) |-> $past(host_idle));

    a_r11_grant_after_init: assert property (@(posedge clk) disable iff (rst)
        bus_grant |-> init_done);
endmodule

bind sdr_init_refresh_seq sdr_seq_checker #(
    .ADDR_W      (ADDR_W),
    .POWERUP_CYC (POWERUP_CYC),
    .TRP_CYC     (TRP_CYC),
    .TRC_CYC     (TRC_CYC),
    .TMRD_CYC    (TMRD_CYC),
    .INIT_REFS   (INIT_REFS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd       ({sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n}),
    .addr      (sdr_addr),
    .bank      (sdr_bank),
    .init_done (init_done),
    .bus_grant (bus_grant),
    .cfg_error (cfg_error),
    .host_idle (host_idle)
);

// File: tb/sdr_init_refresh_seq_bench.sv
module sdr_init_refresh_seq_bench;
    localparam int CLK_NS  = 20;
    localparam int PU_NS   = 2000;
    localparam int TRPN    = 20;
    localparam int TRCN    = 70;
    localparam int TMRD    = 2;
    localparam int REFIN   = 4000;
    localparam int NREF    = 8;
    localparam int AW      = 11;

    localparam int P_C    = (PU_NS + CLK_NS - 1) / CLK_NS;
    localparam int TRP_C  = (TRPN + CLK_NS - 1) / CLK_NS;
    localparam int TRC_C  = (TRCN + CLK_NS - 1) / CLK_NS;
    localparam int REFI_C = REFIN / CLK_NS;

    localparam logic [3:0] K_NOP = 4'b0111;
    localparam logic [3:0] K_PRE = 4'b0010;
    localparam logic [3:0] K_REF = 4'b0001;
    localparam logic [3:0] K_MRS = 4'b0000;

    // {mrs_first, cas_lat[2:0], burst_type, burst_len[2:0], legal}
    localparam logic [8:0] VEC [8] = '{
        9'b0_010_0_010_1,
        9'b1_011_1_011_1,
        9'b0_001_0_111_1,
        9'b1_010_0_000_1,
        9'b0_100_0_001_0,
        9'b1_010_1_111_0,
        9'b0_000_0_010_0,
        9'b1_011_0_101_0
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] cl = 3'd2;
    logic bt = 1'b0;
    logic [2:0] bl = 3'd2;
    logic mf = 1'b0;
    logic host_idle = 1'b0;
    logic cs_n, ras_n, cas_n, we_n, bank, init_done, bus_grant, cfg_error;
    logic [AW-1:0] addr;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int n_log = 0;
    int done_cyc = -1;
    logic [3:0]    log_k [64];
    int            log_c [64];
    logic [AW-1:0] log_a [64];
    logic          log_b [64];

    always #10 clk = ~clk;

    sdr_init_refresh_seq #(
        .ADDR_W(AW), .CLK_PERIOD_NS(CLK_NS), .POWERUP_NS(PU_NS), .TRP_NS(TRPN),
        .TRC_NS(TRCN), .TMRD_CYC(TMRD), .REFI_NS(REFIN), .INIT_REFS(NREF)
    ) u_sdr_init_refresh_seq (
        .clk(clk), .rst(rst), .cfg_cas_lat(cl), .cfg_burst_type(bt), .cfg_burst_len(bl),
        .cfg_mrs_first(mf), .host_idle(host_idle), .sdr_cs_n(cs_n), .sdr_ras_n(ras_n),
        .sdr_cas_n(cas_n), .sdr_we_n(we_n), .sdr_bank(bank), .sdr_addr(addr),
        .init_done(init_done), .bus_grant(bus_grant), .cfg_error(cfg_error)
    );

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (rst) begin
            n_log = 0;
            done_cyc = -1;
        end else begin
            if ({cs_n, ras_n, cas_n, we_n} != K_NOP && n_log < 64) begin
                log_k[n_log] = {cs_n, ras_n, cas_n, we_n};
                log_c[n_log] = cyc;
                log_a[n_log] = addr;
                log_b[n_log] = bank;
                n_log = n_log + 1;
            end
            if (init_done && done_cyc < 0) done_cyc = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int gap_of(input logic [3:0] k);
        if (k == K_PRE) return TRP_C;
        if (k == K_REF) return TRC_C;
        return TMRD;
    endfunction

    function automatic int count_of(input logic [3:0] k);
        int c = 0;
        for (int i = 0; i < n_log; i++) if (log_k[i] == k) c++;
        return c;
    endfunction

    function automatic int index_of(input logic [3:0] k);
        for (int i = 0; i < n_log; i++) if (log_k[i] == k) return i;
        return -1;
    endfunction

    task automatic do_reset(input logic [8:0] v);
        @(negedge clk);
        rst = 1'b1;
        mf = v[8]; cl = v[7:5]; bt = v[4]; bl = v[3:1];
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        // R1: state during reset
        repeat (2) @(negedge clk);
        chk({cs_n, ras_n, cas_n, we_n} == K_NOP, "R1 reset pins", {cs_n, ras_n, cas_n, we_n}, K_NOP);
        chk(!init_done && !bus_grant && !cfg_error, "R1 reset flags",
            {init_done, bus_grant, cfg_error}, 0);

        foreach (VEC[vi]) begin
            logic [8:0] v;
            int mi;
            bit gaps_ok;
            v = VEC[vi];
            do_reset(v);
            repeat (3 * NREF * TRC_C + P_C + 20) @(negedge clk);
            chk(n_log > 0 && log_k[0] == K_PRE && log_a[0][10], "R2 first command precharge-all",
                (n_log > 0) ? log_k[0] : -1, K_PRE);
            chk(n_log > 0 && log_c[0] == P_C + 1, "R1 power-up wait length",
                (n_log > 0) ? log_c[0] : -1, P_C + 1);
            mi = index_of(K_MRS);
            if (v[0]) begin
                chk(count_of(K_REF) == NREF, "R3 init refresh count", count_of(K_REF), NREF);
                chk(mi == (v[8] ? 1 : NREF + 1), "R4 mode write position", mi, v[8] ? 1 : NREF + 1);
                chk(mi >= 0 && log_a[mi] == AW'(v[7:1]) && !log_b[mi], "R5 mode word",
                    (mi >= 0) ? int'(log_a[mi]) : -1, int'(v[7:1]));
                gaps_ok = 1'b1;
                for (int i = 1; i < n_log; i++)
                    if (log_c[i] - log_c[i-1] != gap_of(log_k[i-1])) gaps_ok = 1'b0;
                chk(gaps_ok, "R7 R8 command spacing", gaps_ok, 1);
                chk(done_cyc == log_c[n_log-1] + gap_of(log_k[n_log-1]), "R11 init_done timing",
                    done_cyc, log_c[n_log-1] + gap_of(log_k[n_log-1]));
                chk(!cfg_error, "R6 no error on legal setting", cfg_error, 0);
            end else begin
                chk(cfg_error, "R6 error flag raised", cfg_error, 1);
                chk(mi < 0, "R6 reserved setting not written", mi, -1);
                chk(!init_done && !bus_grant, "R6 init stalled", init_done, 0);
                chk(count_of(K_REF) == (v[8] ? 0 : NREF), "R4 stall point",
                    count_of(K_REF), v[8] ? 0 : NREF);
            end
        end

        // R6: repair a stalled setting, then R9/R10/R11 refresh handshake
        begin
            int x, mi, pre_i, base;
            do_reset(9'b0_000_0_010_0);
            repeat (P_C + NREF * TRC_C + 20) @(negedge clk);
            x = cyc;
            cl = 3'd3;
            repeat (5) @(negedge clk);
            mi = index_of(K_MRS);
            chk(mi >= 0 && log_c[mi] == x + 1, "R6 write after repair",
                (mi >= 0) ? log_c[mi] : -1, x + 1);
            chk(!cfg_error, "R6 error cleared", cfg_error, 0);
            chk(done_cyc == x + 1 + TMRD, "R11 done after repair", done_cyc, x + 1 + TMRD);
            chk(bus_grant, "R11 grant after init", bus_grant, 1);
            while (bus_grant && cyc < done_cyc + REFI_C + 10) @(negedge clk);
            chk(!bus_grant && cyc == done_cyc + REFI_C, "R9 request interval", cyc, done_cyc + REFI_C);
            base = n_log;
            repeat (20) @(negedge clk);
            chk(n_log == base && !bus_grant, "R10 held while host busy", n_log, base);
            x = cyc;
            host_idle = 1'b1;
            @(negedge clk);
            host_idle = 1'b0;
            repeat (TRP_C + TRC_C + 3) @(negedge clk);
            pre_i = base;
            chk(n_log >= base + 2 && log_k[pre_i] == K_PRE && log_a[pre_i][10] && log_c[pre_i] == x + 1,
                "R10 precharge-all on idle", (n_log > base) ? log_c[pre_i] : -1, x + 1);
            chk(n_log >= base + 2 && log_k[pre_i+1] == K_REF && log_c[pre_i+1] == x + 1 + TRP_C,
                "R10 refresh after tRP", (n_log > base + 1) ? log_c[pre_i+1] : -1, x + 1 + TRP_C);
            chk(bus_grant, "R11 grant returned", bus_grant, 1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule